// File: doc/BRIEF.md
# Dual-Bank Kernel Coefficient Store

This block keeps two complete 3x3 convolution kernels, each of nine 8-bit weights labelled A to I. One kernel is always active. All nine of its weights are presented at the same time on a registered parallel bus that feeds a multiplier array. The other kernel is idle. A host may rewrite it while the active one keeps feeding the multipliers. A single address-coded command then swaps the two kernels at run time, which allows adaptive filtering without stalling the pixel stream.

The host port has a 3-bit address, an 8-bit data bus, a chip select and a load strobe, all sampled on the system clock. A write is taken in the clock cycle where the strobe is first seen high while chip select is high. The address decides what the write means. It is either the next weight of one bank, or a choice of the active bank. Each bank sequences its own weights through a write index, so the host only streams values.

Top module: `kernel_coef_store`

## Requirements
- R1: Synchronous reset (active high) makes bank 0 active, clears every stored weight to zero, drives all outputs to zero and points both write indices at weight A.
- R2: A host write is accepted only in a cycle where `cs_i` and `ld_i` are both 1 and `ld_i` was 0 in the previous cycle. Holding `ld_i` high gives a single write, and a strobe with `cs_i` at 0 does nothing.
- R3: Address 3'b010 writes the data to the next weight of bank 0, and address 3'b011 writes it to the next weight of bank 1.
- R4: Successive weight writes to one bank fill A, B, C through I in that order. Weight k (A=0 … I=8) appears on `coefs_o[8k+7:8k]`.
- R5: After weight I, the write index of that bank wraps, so a tenth write replaces A.
- R6: A weight write to a bank restarts at A when the previous decoded command was not a weight write to that same bank. Such a previous command can be a write to the other bank or a bank select.
- R7: Address 3'b101 makes bank 0 active, and address 3'b110 makes bank 1 active. The selection holds until the next such command.
- R8: An accepted write or select changes the stored state at the clock edge that samples it. `coefs_o` and `bank_o` reflect that change from the following clock edge.
- R9: Writing the idle bank leaves `coefs_o` unchanged.
- R10: Writes to any address other than 010, 011, 101 and 110 change no weight, no selection and no write index. They also do not count as an intervening command for R6.
- R11: `bank_o` names the bank whose weights are on `coefs_o` in the same cycle. On a bank switch, all nine weights change together in one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cs_i | input | 1 | Host chip select |
| ld_i | input | 1 | Host load strobe; a write occurs on its rising edge |
| addr_i | input | 3 | Host command address |
| data_i | input | 8 | Host weight data |
| coefs_o | output | 72 | Nine weights of the active bank, A in the lowest byte |
| bank_o | output | 1 | Bank currently driving `coefs_o` |

## Verification
The bench runs a behavioural model of both banks, their write indices and the selection alongside the design, and compares the whole output bus on every clock. The targeted corner cases are these:
- The tenth write to a bank. A design without the wrap would write past I or stall.
- The index restart after a write to the other bank or a bank select. Getting this wrong misplaces weights.
- Ignored addresses placed between two writes to the same bank. A design that decodes them would restart the sequence or corrupt a bank.
- A load strobe held high for several cycles, and a strobe while chip select is low. Mishandling these would give repeated or spurious writes.
- The exact cycle of a bank swap. An off-by-one design shows the new kernel a cycle early or late, or shows a mix of the two kernels.

// File: rtl/kcs_pkg.sv
package kcs_pkg;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] ADR_LOAD0 = 3'b010;
  localparam logic [ADDR_W-1:0] ADR_LOAD1 = 3'b011;
  localparam logic [ADDR_W-1:0] ADR_USE0  = 3'b101;
  localparam logic [ADDR_W-1:0] ADR_USE1  = 3'b110;

  typedef enum logic [1:0] {
    LAST_NONE  = 2'd0,
    LAST_LOAD0 = 2'd1,
    LAST_LOAD1 = 2'd2,
    LAST_SEL   = 2'd3
  } last_cmd_t;
endpackage

// File: rtl/kcs_host_decode.sv
module kcs_host_decode
  import kcs_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_i,
  input  logic              ld_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CW-1:0]     data_i,
  output logic [1:0]        wr_o,
  output logic [1:0]        restart_o,
  output logic              sel_we_o,
  output logic              sel_bank_o,
  output logic [CW-1:0]     data_o
);

  logic      ld_q;
  logic      stb;
  last_cmd_t last_q;

  assign stb    = cs_i & ld_i & ~ld_q;
  assign data_o = data_i;

  always_comb begin
    wr_o       = '0;
    restart_o  = '0;
    sel_we_o   = 1'b0;
    sel_bank_o = 1'b0;
    if (stb) begin
      unique case (addr_i)
        ADR_LOAD0: begin
          wr_o[0]      = 1'b1;
          restart_o[0] = (last_q != LAST_LOAD0);
        end
        ADR_LOAD1: begin
          wr_o[1]      = 1'b1;
          restart_o[1] = (last_q != LAST_LOAD1);
        end
        ADR_USE0: begin
          sel_we_o   = 1'b1;
          sel_bank_o = 1'b0;
        end
        ADR_USE1: begin
          sel_we_o   = 1'b1;
          sel_bank_o = 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ld_q   <= 1'b0;
      last_q <= LAST_NONE;
    end else begin
      ld_q <= ld_i;
      if (stb) begin
        unique case (addr_i)
          ADR_LOAD0: last_q <= LAST_LOAD0;
          ADR_LOAD1: last_q <= LAST_LOAD1;
          ADR_USE0:  last_q <= LAST_SEL;
          ADR_USE1:  last_q <= LAST_SEL;
          default: ;
        endcase
      end
    end
  end

  // R2
  single_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    (|{wr_o, sel_we_o}) |=> !(|{wr_o, sel_we_o}));

  // R10
  ignored_addr_chk: assert property (@(posedge clk) disable iff (rst)
    (stb && addr_i != ADR_LOAD0 && addr_i != ADR_LOAD1 &&
     addr_i != ADR_USE0 && addr_i != ADR_USE1) |=> $stable(last_q));

endmodule

// File: rtl/kcs_coef_bank.sv
module kcs_coef_bank #(
  parameter int CW    = 8,
  parameter int NCOEF = 9
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                we_i,
  input  logic                restart_i,
  input  logic [CW-1:0]       data_i,
  output logic [NCOEF*CW-1:0] coefs_o
);

  localparam int IW = (NCOEF > 1) ? $clog2(NCOEF) : 1;
  localparam logic [IW-1:0] LAST_SLOT = IW'(NCOEF - 1);

  logic [CW-1:0] mem [NCOEF];
  logic [IW-1:0] idx;
  logic [IW-1:0] slot;

  assign slot = restart_i ? '0 : idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      idx <= '0;
      for (int k = 0; k < NCOEF; k++) mem[k] <= '0;
    end else if (we_i) begin
      mem[slot] <= data_i;
      idx       <= (slot == LAST_SLOT) ? '0 : slot + 1'b1;
    end
  end

  for (genvar k = 0; k < NCOEF; k++) begin : g_out
    assign coefs_o[k*CW +: CW] = mem[k];
  end

  // R5
  idx_bound_chk: assert property (@(posedge clk) disable iff (rst)
    idx <= LAST_SLOT);

  // R6
  restart_chk: assert property (@(posedge clk) disable iff (rst)
    (we_i && restart_i) |=> (mem[0] == $past(data_i)));

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !we_i |=> $stable(coefs_o));

endmodule

// File: rtl/kcs_coef_select.sv
module kcs_coef_select #(
  parameter int CW    = 8,
  parameter int NCOEF = 9
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                sel_we_i,
  input  logic                sel_bank_i,
  input  logic [NCOEF*CW-1:0] bank0_i,
  input  logic [NCOEF*CW-1:0] bank1_i,
  output logic [NCOEF*CW-1:0] coefs_o,
  output logic                bank_o
);

  logic act_q;
  logic bank_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q  <= 1'b0;
      bank_q <= 1'b0;
    end else begin
      if (sel_we_i) act_q <= sel_bank_i;
      bank_q <= act_q;
    end
  end

  for (genvar k = 0; k < NCOEF; k++) begin : g_lane
    logic [CW-1:0] lane_q;
    always_ff @(posedge clk) begin
      if (rst) lane_q <= '0;
      else     lane_q <= act_q ? bank1_i[k*CW +: CW] : bank0_i[k*CW +: CW];
    end
    assign coefs_o[k*CW +: CW] = lane_q;
  end

  assign bank_o = bank_q;

  // R7
  sel_apply_chk: assert property (@(posedge clk) disable iff (rst)
    sel_we_i |=> (act_q == $past(sel_bank_i)));

  // R7
  sel_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !sel_we_i |=> $stable(act_q));

  // R11
  out_src_chk: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (bank_o == $past(act_q)));

endmodule

// File: rtl/kernel_coef_store.sv
module kernel_coef_store
  import kcs_pkg::*;
#(
  parameter int CW    = 8,
  parameter int NCOEF = 9
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cs_i,
  input  logic                ld_i,
  input  logic [2:0]          addr_i,
  input  logic [CW-1:0]       data_i,
  output logic [NCOEF*CW-1:0] coefs_o,
  output logic                bank_o
);

  localparam int NBANK = 2;

  logic [NBANK-1:0]    wr;
  logic [NBANK-1:0]    restart;
  logic                sel_we;
  logic                sel_bank;
  logic [CW-1:0]       wdata;
  logic [NCOEF*CW-1:0] bank_flat [NBANK];

  kcs_host_decode #(.CW(CW)) u_dec (
    .clk        (clk),
    .rst        (rst),
    .cs_i       (cs_i),
    .ld_i       (ld_i),
    .addr_i     (addr_i),
    .data_i     (data_i),
    .wr_o       (wr),
    .restart_o  (restart),
    .sel_we_o   (sel_we),
    .sel_bank_o (sel_bank),
    .data_o     (wdata)
  );

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    kcs_coef_bank #(.CW(CW), .NCOEF(NCOEF)) u_bank (
      .clk       (clk),
      .rst       (rst),
      .we_i      (wr[b]),
      .restart_i (restart[b]),
      .data_i    (wdata),
      .coefs_o   (bank_flat[b])
    );
  end

  kcs_coef_select #(.CW(CW), .NCOEF(NCOEF)) u_sel (
    .clk        (clk),
    .rst        (rst),
    .sel_we_i   (sel_we),
    .sel_bank_i (sel_bank),
    .bank0_i    (bank_flat[0]),
    .bank1_i    (bank_flat[1]),
    .coefs_o    (coefs_o),
    .bank_o     (bank_o)
  );

endmodule

// File: tb/test_kernel_coef_store.sv
`timescale 1ns/1ps
module test_kernel_coef_store;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cs = 1'b0;
  logic        ld = 1'b0;
  logic [2:0]  addr = 3'd0;
  logic [7:0]  din = 8'd0;
  logic [71:0] coefs;
  logic        bank;

  int    total = 0;
  int    bad = 0;
  bit    cmp_on = 1'b0;
  bit    done = 1'b0;
  string cur_req = "R1";

  always #10 clk = ~clk;

  kernel_coef_store i_kernel_coef_store (
    .clk(clk), .rst(rst), .cs_i(cs), .ld_i(ld), .addr_i(addr),
    .data_i(din), .coefs_o(coefs), .bank_o(bank)
  );

  // behavioural reference
  int          m_mem [2][9];
  int          m_idx [2];
  int          m_last;
  int          m_act;
  bit          m_ldp;
  logic [71:0] exp_coefs;
  logic        exp_bank;

  task automatic m_load(int b, int d);
    if (m_last != b + 1) m_idx[b] = 0;
    m_mem[b][m_idx[b]] = d;
    m_idx[b] = (m_idx[b] == 8) ? 0 : m_idx[b] + 1;
    m_last = b + 1;
  endtask

  always @(posedge clk) begin
    if (rst) begin
      for (int b = 0; b < 2; b++) begin
        m_idx[b] = 0;
        for (int k = 0; k < 9; k++) m_mem[b][k] = 0;
      end
      m_last = 0; m_act = 0; m_ldp = 1'b0;
      exp_coefs = '0; exp_bank = 1'b0;
    end else begin
      for (int k = 0; k < 9; k++) exp_coefs[k*8 +: 8] = 8'(m_mem[m_act][k]);
      exp_bank = 1'(m_act);
      if (cs && ld && !m_ldp) begin
        case (addr)
          3'b010: m_load(0, int'(din));
          3'b011: m_load(1, int'(din));
          3'b101: begin m_act = 0; m_last = 3; end
          3'b110: begin m_act = 1; m_last = 3; end
          default: ;
        endcase
      end
      m_ldp = ld;
    end
  end

  always @(negedge clk) begin
    if (cmp_on && !done) begin
      total++;
      if (coefs !== exp_coefs || bank !== exp_bank) begin
        bad++;
        $display("FAIL %s per-cycle: actual coefs=%h bank=%0d expected coefs=%h bank=%0d",
                 cur_req, coefs, bank, exp_coefs, exp_bank);
      end
    end
  end

  task automatic chk(string req, logic [71:0] act, logic [71:0] expv);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, expv);
    end
  endtask

  function automatic logic [7:0] cf(int k);
    return coefs[k*8 +: 8];
  endfunction

  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk); cs = 1'b1; ld = 1'b1; addr = a; din = d;
    @(negedge clk); cs = 1'b0; ld = 1'b0;
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [71:0] v;
    @(posedge clk); cmp_on = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1", coefs, 72'd0);
    chk("R1", 72'(bank), 72'd0);

    // R3 R4: fill bank 0 in order
    cur_req = "R4";
    for (int k = 0; k < 9; k++) wr(3'b010, 8'(8'h10 + k));
    settle();
    for (int k = 0; k < 9; k++) v[k*8 +: 8] = 8'(8'h10 + k);
    chk("R4", coefs, v);
    chk("R3", 72'(bank), 72'd0);

    // R9: idle bank 1 loaded, outputs unchanged
    cur_req = "R9";
    for (int k = 0; k < 9; k++) wr(3'b011, 8'(8'h20 + k));
    settle();
    chk("R9", coefs, v);

    // R7 R8 R11: switch to bank 1
    cur_req = "R8";
    wr(3'b110, 8'h00);
    chk("R8", 72'(bank), 72'd0);
    chk("R8", 72'(cf(0)), 72'h10);
    @(negedge clk);
    for (int k = 0; k < 9; k++) v[k*8 +: 8] = 8'(8'h20 + k);
    chk("R11", coefs, v);
    chk("R7", 72'(bank), 72'd1);

    // R9: rewrite bank 0 while bank 1 active
    cur_req = "R9";
    for (int k = 0; k < 9; k++) wr(3'b010, 8'(8'h30 + k));
    settle();
    chk("R9", coefs, v);

    // R5: ten writes to bank 1, tenth replaces A
    cur_req = "R5";
    for (int k = 0; k < 10; k++) wr(3'b011, 8'(8'h40 + k));
    settle();
    chk("R5", 72'(cf(0)), 72'h49);
    chk("R5", 72'(cf(1)), 72'h41);
    chk("R5", 72'(cf(8)), 72'h48);

    // R6: continue, then restart after other-bank write
    cur_req = "R6";
    wr(3'b011, 8'h50);
    wr(3'b010, 8'h60);
    wr(3'b011, 8'h51);
    settle();
    chk("R6", 72'(cf(0)), 72'h51);
    chk("R6", 72'(cf(1)), 72'h50);

    // R10: ignored addresses between writes
    cur_req = "R10";
    wr(3'b011, 8'h52);
    wr(3'b111, 8'h99);
    wr(3'b000, 8'h77);
    wr(3'b100, 8'h66);
    wr(3'b001, 8'h55);
    wr(3'b011, 8'h53);
    settle();
    chk("R10", 72'(cf(0)), 72'h51);
    chk("R10", 72'(cf(1)), 72'h52);
    chk("R10", 72'(cf(2)), 72'h53);
    chk("R10", 72'(bank), 72'd1);

    // R2: held strobe gives one write; cs low strobe ignored
    cur_req = "R2";
    @(negedge clk); cs = 1'b1; ld = 1'b1; addr = 3'b011; din = 8'h54;
    repeat (4) @(negedge clk);
    cs = 1'b0; ld = 1'b0;
    settle();
    chk("R2", 72'(cf(3)), 72'h54);
    chk("R2", 72'(cf(4)), 72'h44);
    @(negedge clk); cs = 1'b0; ld = 1'b1; addr = 3'b011; din = 8'h55;
    @(negedge clk); ld = 1'b0;
    settle();
    chk("R2", 72'(cf(4)), 72'h44);
    wr(3'b011, 8'h56);
    settle();
    chk("R2", 72'(cf(4)), 72'h56);
    chk("R2", 72'(cf(5)), 72'h45);

    // R7: back to bank 0
    cur_req = "R7";
    wr(3'b101, 8'h00);
    settle();
    chk("R7", 72'(bank), 72'd0);
    chk("R7", 72'(cf(0)), 72'h60);
    chk("R7", 72'(cf(8)), 72'h38);

    // R1: reset mid-run, then index back at A
    cur_req = "R1";
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", coefs, 72'd0);
    chk("R1", 72'(bank), 72'd0);
    wr(3'b010, 8'h01);
    settle();
    chk("R1", 72'(cf(0)), 72'h01);
    chk("R1", 72'(cf(1)), 72'h00);

    finish_run();
  end

endmodule